// File: doc/BRIEF.md
# External Memory Bus Port Multiplexer

This block decides what the two address/data ports of an 8-bit microcontroller drive during external memory cycles. A request names a cycle kind (code fetch, data access with a 16-bit address, data access with an 8-bit address), an address, write data and a write flag. The block then runs a fixed two-phase bus cycle. In the first phase the low port presents the low address byte while an address-latch strobe is high. In the second phase it either drives the write byte or releases the pins and samples the returned byte. Only one active-low strobe is active during the second phase: code read, data read or data write.

The high port carries the upper address byte for code fetches and 16-bit data accesses. During 8-bit data accesses it keeps showing its own port latch. Between cycles both ports return to their latch values. The low port is open-drain: a latch bit of 1 releases the pin so it can be used as an input. The block owns the low port latch. It loads the latch only while the bus is idle and fills it with ones after every external cycle.

Top module: `ext_bus_mux`

## Requirements
- R1: After reset, `busy`, `addr_strobe` and `rd_valid` are 0, all three strobes (`code_rd_n`, `data_rd_n`, `data_wr_n`) are 1, and the low latch holds 0xFF, so `lo_oe` is 0x00.
- R2: While idle, `lo_out` equals the low latch and `lo_oe[i]` is the inverse of latch bit i. A 1 releases the pin. `hi_out` follows `hi_latch`.
- R3: A cycle starts when `cyc_go` is high in an idle clock and `cyc_kind` is not 2'b00. The encodings are 2'b01 code fetch, 2'b10 data with 16-bit address, and 2'b11 data with 8-bit address. `busy` is high for ADDR_CYC+DATA_CYC clocks starting with the next clock. A request made while busy, or with kind 2'b00, is ignored.
- R4: For the first ADDR_CYC clocks of a cycle, `addr_strobe` is 1, `lo_out` carries address bits 7:0 and `lo_oe` is 0xFF. It is 0 at all other times.
- R5: Throughout a cycle, `hi_out` carries address bits 15:8 for kinds 01 and 10. For kind 11 it carries the live `hi_latch` value.
- R6: A data-kind cycle with `wr_flag`=1 is a write. For its last DATA_CYC clocks, `lo_out` is the write byte, `lo_oe` is 0xFF and `data_wr_n` is 0.
- R7: Every other cycle is a read, including a code fetch whatever `wr_flag` is. For its last DATA_CYC clocks, `lo_oe` is 0x00 and the strobe is low: `code_rd_n` for a code fetch, `data_rd_n` for a data read. `lo_pin` is captured on the final clock. The clock after that, `rd_valid` pulses for one clock and `rd_byte` shows the captured byte.
- R8: At most one of `code_rd_n`, `data_rd_n` and `data_wr_n` is 0 in any clock.
- R9: After any external cycle ends, the low latch is 0xFF.
- R10: `lo_ld` with `lo_ld_val` writes the low latch only in an idle clock. A load while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_go | input | 1 | Request a bus cycle |
| cyc_kind | input | 2 | Cycle kind: 00 none, 01 code, 10 data 16-bit, 11 data 8-bit |
| cyc_addr | input | 16 | Cycle address |
| cyc_wdata | input | 8 | Write byte |
| wr_flag | input | 1 | 1 = write (data kinds only) |
| hi_latch | input | 8 | High port latch value |
| lo_ld | input | 1 | Load the low port latch |
| lo_ld_val | input | 8 | Value for the low port latch |
| lo_pin | input | 8 | Sampled low port pins |
| lo_out | output | 8 | Low port output value |
| lo_oe | output | 8 | Low port per-pin drive enable |
| hi_out | output | 8 | High port output value |
| addr_strobe | output | 1 | Address latch strobe, active high |
| code_rd_n | output | 1 | Code memory read strobe, active low |
| data_rd_n | output | 1 | Data read strobe, active low |
| data_wr_n | output | 1 | Data write strobe, active low |
| busy | output | 1 | Cycle in progress |
| rd_byte | output | 8 | Captured read byte |
| rd_valid | output | 1 | One-clock pulse: rd_byte is new |

## Verification
The assertions check several properties in every clock. Only one strobe is low at a time. The low port drives while the address strobe or write strobe is active, and floats whenever a read strobe is low. The latch is full of ones after each cycle and does not change during the address phase. A read-valid pulse follows only a read cycle. Other behaviours can only be shown by the bench's scenarios, where a cycle-level reference model is compared every clock. These include the exact phase lengths, which address byte appears on which port for each kind, a live change of the high latch during an 8-bit access, and the rejection of requests that are mistimed or have kind 00.

// File: rtl/ebm_pkg.sv
package ebm_pkg;
    typedef enum logic [1:0] {
        CYC_NONE = 2'b00,
        CYC_CODE = 2'b01,
        CYC_D16  = 2'b10,
        CYC_D8   = 2'b11
    } cyc_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_ADDR = 2'b01,
        PH_DATA = 2'b10
    } phase_e;

    function automatic logic bus_is_write(cyc_e kind, logic wr);
        return wr && (kind != CYC_CODE);
    endfunction
endpackage

// File: rtl/ebm_seq.sv
module ebm_seq
    import ebm_pkg::*;
#(
    parameter int ADDR_CYC = 2,
    parameter int DATA_CYC = 3,
    parameter int AW       = 16,
    parameter int DW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  cyc_e          kind,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          wr,
    input  logic          ld,
    input  logic [DW-1:0] ld_val,
    input  logic [DW-1:0] pin,
    output phase_e        phase,
    output cyc_e          cur_kind,
    output logic [AW-1:0] cur_addr,
    output logic [DW-1:0] cur_wdata,
    output logic          cur_wr,
    output logic [DW-1:0] latch,
    output logic [DW-1:0] rbyte,
    output logic          rvalid
);
    localparam int MAXC = (ADDR_CYC > DATA_CYC) ? ADDR_CYC : DATA_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
        cyc_e          kind;
        logic [AW-1:0] addr;
        logic [DW-1:0] wd;
        logic          wr;
        logic [DW-1:0] latch;
        logic [DW-1:0] rbyte;
        logic          rvalid;
    } seq_s;

    seq_s s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.rvalid = 1'b0;
        case (s_q.ph)
            PH_IDLE: begin
                if (ld) s_d.latch = ld_val;
                if (go && (kind != CYC_NONE)) begin
                    s_d.ph   = PH_ADDR;
                    s_d.cnt  = CW'(ADDR_CYC - 1);
                    s_d.kind = kind;
                    s_d.addr = addr;
                    s_d.wd   = wdata;
                    s_d.wr   = wr;
                end
            end
            PH_ADDR: begin
                if (s_q.cnt == '0) begin
                    s_d.ph  = PH_DATA;
                    s_d.cnt = CW'(DATA_CYC - 1);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_DATA: begin
                if (s_q.cnt == '0) begin
                    s_d.ph    = PH_IDLE;
                    s_d.latch = '1;
                    if (!bus_is_write(s_q.kind, s_q.wr)) begin
                        s_d.rbyte  = pin;
                        s_d.rvalid = 1'b1;
                    end
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, cnt: '0, kind: CYC_NONE, addr: '0, wd: '0,
                     wr: 1'b0, latch: '1, rbyte: '0, rvalid: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign phase     = s_q.ph;
    assign cur_kind  = s_q.kind;
    assign cur_addr  = s_q.addr;
    assign cur_wdata = s_q.wd;
    assign cur_wr    = s_q.wr;
    assign latch     = s_q.latch;
    assign rbyte     = s_q.rbyte;
    assign rvalid    = s_q.rvalid;

    // R9: the latch is all ones once a cycle has closed
    a_r9_latch_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_DATA && s_q.cnt == '0) |=> (s_q.latch == '1));

    // R10: the latch cannot move while the address phase runs
    a_r10_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_ADDR) |=> $stable(s_q.latch));

    // R7: a read-valid pulse only follows a read cycle
    a_r7_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rvalid |-> (s_q.ph == PH_IDLE && !bus_is_write(s_q.kind, s_q.wr)));
endmodule

// File: rtl/ebm_lo_port.sv
module ebm_lo_port
    import ebm_pkg::*;
#(
    parameter int DW = 8
) (
    input  phase_e        phase,
    input  cyc_e          kind,
    input  logic          wr,
    input  logic [DW-1:0] addr_lo,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] latch,
    output logic [DW-1:0] out,
    output logic [DW-1:0] oe
);
    logic drive_wr;
    assign drive_wr = bus_is_write(kind, wr);

    for (genvar i = 0; i < DW; i++) begin : g_pin
        always_comb begin
            case (phase)
                PH_ADDR: begin
                    out[i] = addr_lo[i];
                    oe[i]  = 1'b1;
                end
                PH_DATA: begin
                    out[i] = drive_wr ? wdata[i] : 1'b0;
                    oe[i]  = drive_wr;
                end
                default: begin
                    out[i] = latch[i];
                    oe[i]  = ~latch[i];
                end
            endcase
        end
    end
endmodule

// File: rtl/ebm_hi_port.sv
module ebm_hi_port
    import ebm_pkg::*;
#(
    parameter int DW = 8
) (
    input  phase_e        phase,
    input  cyc_e          kind,
    input  logic [DW-1:0] addr_hi,
    input  logic [DW-1:0] latch,
    output logic [DW-1:0] out
);
    always_comb begin
        if (phase != PH_IDLE && kind != CYC_D8) out = addr_hi;
        else                                    out = latch;
    end
endmodule

// File: rtl/ebm_strobes.sv
module ebm_strobes
    import ebm_pkg::*;
(
    input  phase_e phase,
    input  cyc_e   kind,
    input  logic   wr,
    output logic   ale,
    output logic   code_rd_n,
    output logic   data_rd_n,
    output logic   data_wr_n
);
    logic in_data, is_wr;
    assign in_data = (phase == PH_DATA);
    assign is_wr   = bus_is_write(kind, wr);

    always_comb begin
        ale       = (phase == PH_ADDR);
        code_rd_n = !(in_data && kind == CYC_CODE);
        data_rd_n = !(in_data && kind != CYC_CODE && !is_wr);
        data_wr_n = !(in_data && is_wr);
    end
endmodule

// File: rtl/ext_bus_mux.sv
module ext_bus_mux
    import ebm_pkg::*;
#(
    parameter int ADDR_CYC = 2,
    parameter int DATA_CYC = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc_go,
    input  logic [1:0] cyc_kind,
    input  logic [15:0] cyc_addr,
    input  logic [7:0] cyc_wdata,
    input  logic       wr_flag,
    input  logic [7:0] hi_latch,
    input  logic       lo_ld,
    input  logic [7:0] lo_ld_val,
    input  logic [7:0] lo_pin,
    output logic [7:0] lo_out,
    output logic [7:0] lo_oe,
    output logic [7:0] hi_out,
    output logic       addr_strobe,
    output logic       code_rd_n,
    output logic       data_rd_n,
    output logic       data_wr_n,
    output logic       busy,
    output logic [7:0] rd_byte,
    output logic       rd_valid
);
    localparam int DW = 8;
    localparam int AW = 2 * DW;

    phase_e        phase;
    cyc_e          cur_kind;
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] cur_wdata;
    logic          cur_wr;
    logic [DW-1:0] lo_latch;

    ebm_seq #(.ADDR_CYC(ADDR_CYC), .DATA_CYC(DATA_CYC), .AW(AW), .DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(cyc_go), .kind(cyc_e'(cyc_kind)),
        .addr(cyc_addr), .wdata(cyc_wdata), .wr(wr_flag), .ld(lo_ld),
        .ld_val(lo_ld_val), .pin(lo_pin), .phase(phase), .cur_kind(cur_kind),
        .cur_addr(cur_addr), .cur_wdata(cur_wdata), .cur_wr(cur_wr),
        .latch(lo_latch), .rbyte(rd_byte), .rvalid(rd_valid)
    );

    ebm_lo_port #(.DW(DW)) u_lo (
        .phase(phase), .kind(cur_kind), .wr(cur_wr), .addr_lo(cur_addr[DW-1:0]),
        .wdata(cur_wdata), .latch(lo_latch), .out(lo_out), .oe(lo_oe)
    );

    ebm_hi_port #(.DW(DW)) u_hi (
        .phase(phase), .kind(cur_kind), .addr_hi(cur_addr[AW-1:DW]),
        .latch(hi_latch), .out(hi_out)
    );

    ebm_strobes u_stb (
        .phase(phase), .kind(cur_kind), .wr(cur_wr), .ale(addr_strobe),
        .code_rd_n(code_rd_n), .data_rd_n(data_rd_n), .data_wr_n(data_wr_n)
    );

    assign busy = (phase != PH_IDLE);

    // R8: no two strobes low together
    a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~code_rd_n, ~data_rd_n, ~data_wr_n}) <= 1);

    // R4: address phase owns the whole low port
    a_r4_addr_driven: assert property (@(posedge clk) disable iff (!rst_n)
        addr_strobe |-> (lo_oe == '1));

    // R6: write strobe implies the low port drives
    a_r6_write_driven: assert property (@(posedge clk) disable iff (!rst_n)
        !data_wr_n |-> (lo_oe == '1));

    // R7: read strobes imply the low port floats
    a_r7_read_floats: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_rd_n || !code_rd_n) |-> (lo_oe == '0));
endmodule

// File: tb/sim_ext_bus_mux.sv
module sim_ext_bus_mux;
    localparam int CLK_PERIOD = 10;
    localparam int A = 2;
    localparam int D = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_go = 1'b0;
    logic [1:0] cyc_kind = 2'b00;
    logic [15:0] cyc_addr = '0;
    logic [7:0] cyc_wdata = '0;
    logic wr_flag = 1'b0;
    logic [7:0] hi_latch = 8'hFF;
    logic lo_ld = 1'b0;
    logic [7:0] lo_ld_val = '0;
    logic [7:0] lo_pin = '0;
    logic [7:0] lo_out, lo_oe, hi_out, rd_byte;
    logic addr_strobe, code_rd_n, data_rd_n, data_wr_n, busy, rd_valid;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_bus_mux #(.ADDR_CYC(A), .DATA_CYC(D)) u0 (
        .clk(clk), .rst_n(rst_n), .cyc_go(cyc_go), .cyc_kind(cyc_kind),
        .cyc_addr(cyc_addr), .cyc_wdata(cyc_wdata), .wr_flag(wr_flag),
        .hi_latch(hi_latch), .lo_ld(lo_ld), .lo_ld_val(lo_ld_val), .lo_pin(lo_pin),
        .lo_out(lo_out), .lo_oe(lo_oe), .hi_out(hi_out), .addr_strobe(addr_strobe),
        .code_rd_n(code_rd_n), .data_rd_n(data_rd_n), .data_wr_n(data_wr_n),
        .busy(busy), .rd_byte(rd_byte), .rd_valid(rd_valid)
    );

    // behavioural reference model
    bit m_busy = 0;
    int m_t = 0;
    int m_kind = 0;
    logic [15:0] m_addr = '0;
    logic [7:0] m_wd = '0, m_latch = 8'hFF, m_rbyte = '0;
    bit m_wr = 0, m_rvalid = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_t = 0; m_latch = 8'hFF; m_rvalid = 0;
        end else begin
            m_rvalid = 0;
            if (m_busy) begin
                if (m_t == A + D - 1) begin
                    m_busy = 0;
                    m_latch = 8'hFF;
                    if (!(m_wr && m_kind != 1)) begin
                        m_rbyte = lo_pin; m_rvalid = 1;
                    end
                end else m_t++;
            end else begin
                if (lo_ld) m_latch = lo_ld_val;
                if (cyc_go && cyc_kind != 2'b00) begin
                    m_busy = 1; m_t = 0; m_kind = int'(cyc_kind);
                    m_addr = cyc_addr; m_wd = cyc_wdata; m_wr = wr_flag;
                end
            end
        end
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        bit ale_e, dph, wr_e;
        string lreq;
        logic [7:0] oe_e, out_e, hi_e;
        ale_e = m_busy && m_t < A;
        dph   = m_busy && m_t >= A;
        wr_e  = m_wr && m_kind != 1;
        if (!m_busy)   begin oe_e = ~m_latch; out_e = m_latch; lreq = "R2"; end
        else if (ale_e) begin oe_e = 8'hFF; out_e = m_addr[7:0]; lreq = "R4"; end
        else if (wr_e)  begin oe_e = 8'hFF; out_e = m_wd; lreq = "R6"; end
        else            begin oe_e = 8'h00; out_e = lo_out; lreq = "R7"; end
        hi_e = (m_busy && m_kind != 3) ? m_addr[15:8] : hi_latch;
        chk(lreq, "lo_oe", lo_oe, oe_e);
        chk(lreq, "lo_out", lo_out, out_e);
        chk(m_busy ? "R5" : "R2", "hi_out", hi_out, hi_e);
        chk("R4", "addr_strobe", addr_strobe, ale_e);
        chk("R3", "busy", busy, m_busy);
        chk("R7", "code_rd_n", code_rd_n, !(dph && m_kind == 1));
        chk("R7", "data_rd_n", data_rd_n, !(dph && m_kind != 1 && !wr_e));
        chk("R6", "data_wr_n", data_wr_n, !(dph && wr_e));
        chk("R8", "strobe_count", 32'($countones({~code_rd_n, ~data_rd_n, ~data_wr_n})) <= 1, 1);
        chk("R7", "rd_valid", rd_valid, m_rvalid);
        if (m_rvalid) chk("R7", "rd_byte", rd_byte, m_rbyte);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic run_cycle(logic [1:0] k, logic [15:0] a, logic [7:0] w, logic wr, logic [7:0] pin);
        cyc_go = 1; cyc_kind = k; cyc_addr = a; cyc_wdata = w; wr_flag = wr; lo_pin = pin;
        tick();
        cyc_go = 0; cyc_kind = 2'b00;
        repeat (A + D) tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1", "busy", busy, 0);
        chk("R1", "addr_strobe", addr_strobe, 0);
        chk("R1", "strobes", {code_rd_n, data_rd_n, data_wr_n}, 3'b111);
        chk("R1", "lo_oe", lo_oe, 8'h00);
        chk("R1", "rd_valid", rd_valid, 0);
        tick();
        // R2/R10: idle load of the low latch
        lo_ld = 1; lo_ld_val = 8'hA5; hi_latch = 8'h3C;
        tick();
        lo_ld = 0;
        tick();
        chk("R10", "lo_out_idle_load", lo_out, 8'hA5);
        chk("R2", "lo_oe_idle", lo_oe, 8'h5A);
        // R3: kind 00 is ignored
        cyc_go = 1; cyc_kind = 2'b00;
        tick();
        cyc_go = 0;
        tick();
        chk("R3", "busy_kind_none", busy, 0);
        // R7: code fetch, wr_flag ignored
        run_cycle(2'b01, 16'h12F0, 8'h77, 1'b1, 8'hC3);
        tick();
        chk("R9", "lo_oe_after_code", lo_oe, 8'h00);
        // R6: 16-bit data write
        lo_ld = 1; lo_ld_val = 8'h0F; tick(); lo_ld = 0;
        run_cycle(2'b10, 16'hBEEF, 8'h5D, 1'b1, 8'h00);
        tick();
        chk("R9", "lo_out_after_write", lo_out, 8'hFF);
        // R7: 16-bit data read
        run_cycle(2'b10, 16'h4321, 8'h00, 1'b0, 8'h9A);
        tick();
        // R5: 8-bit read with live high latch change
        cyc_go = 1; cyc_kind = 2'b11; cyc_addr = 16'hAA55; wr_flag = 0; lo_pin = 8'h66;
        tick();
        cyc_go = 0; cyc_kind = 2'b00;
        tick();
        hi_latch = 8'hE1;
        repeat (A + D - 1) tick();
        chk("R5", "hi_out_d8_live", hi_out, 8'hE1);
        // R3/R10: request and load while busy are ignored
        cyc_go = 1; cyc_kind = 2'b11; cyc_addr = 16'h0102; cyc_wdata = 8'h3E; wr_flag = 1;
        tick();
        cyc_go = 1; cyc_kind = 2'b10; cyc_addr = 16'hFFFF;
        lo_ld = 1; lo_ld_val = 8'h00;
        tick();
        cyc_go = 0; cyc_kind = 2'b00; lo_ld = 0;
        repeat (A + D - 1) tick();
        chk("R3", "busy_after_ignored_go", busy, 0);
        chk("R10", "lo_oe_after_busy_load", lo_oe, 8'h00);
        // back-to-back: start in the first idle clock
        run_cycle(2'b11, 16'h7788, 8'hC4, 1'b1, 8'h00);
        run_cycle(2'b01, 16'h0000, 8'h00, 1'b0, 8'h00);
        run_cycle(2'b10, 16'hFF00, 8'h00, 1'b0, 8'hFF);
        repeat (3) tick();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule